// File: doc/BRIEF.md
# Vertical Microword Control Decoder

This block sits after the control store of a small accumulator-based processor. On each cycle in which the sequencer presents a valid microword, the block captures the 18-bit control part of that word in a control data register. It then expands the packed fields into the individual control lines that the datapath uses: register increments, loads and clears, memory strobes, ALU operation selects, flag resets and the 3-bit bus source select.

The word holds six 3-bit fields. Each field packs a set of signals that can never be active together. The field at the most significant end is the bus source select, which is passed through without decoding. Each of the other five fields goes to its own small decoder, and code zero in those fields means no operation. Packing the signals this way stores 18 bits per microword instead of one bit per control line. The output-register load and the output-ready flag reset always occur together, so they share one code. The next-address part of the microword, the control store itself and the datapath are outside this block.

Top module: `ucw_decode`

## Requirements
- R1: While `rst` is high at a rising edge, the register clears to all zeros. In the following cycle `bus_sel` is 000 and every decoded line is 0.
- R2: When `cw_load` is high at a rising edge, the register captures `cw_in`. The outputs show the new word from that edge on.
- R3: When `cw_load` is low at a rising edge, the register keeps its word, and none of the outputs changes whatever `cw_in` carries.
- R4: `bus_sel` equals bits 17:15 of the registered word, with no decoding.
- R5: Bits 14:12 drive `addr_pc_ctl`. Code k (1..7) sets bit k-1 only. In bit order 0..6 the lines are: address reg increment, address reg load, address reg clear, program counter increment, program counter load, program counter clear, extension bit reset.
- R6: Bits 11:9 drive `acc_dr_ctl`. Code k (1..7) sets bit k-1 only. In bit order 0..6 the lines are: accumulator increment, accumulator load, accumulator clear, data reg increment, data reg load, data reg clear, instruction reg load.
- R7: Bits 8:6 drive `mem_tr_ctl`. Code k (1..7) sets bit k-1 only. In bit order 0..6 the lines are: memory read, memory write, temp reg increment, temp reg load, temp reg clear, interrupt-pending set, interrupt-pending reset.
- R8: Bits 5:3 select the ALU operation. Codes 1..6 set `alu_op` bit k-1. In bit order 0..5 the operations are: accumulator complement, extension complement, shift right, shift left, AND, add. Code 7 sets `out_load` and leaves `alu_op` at zero.
- R9: Bits 2:0 drive `flag_ctl`. Codes 1..5 set bit k-1. In bit order 0..4 the lines are: interrupt-enable reset, interrupt-enable set, run-state reset, input-ready reset, output-ready reset. Codes 6 and 7 are no-operations.
- R10: Whenever `out_load` is high, `flag_ctl[4]` (output-ready reset) is also high.
- R11: Code 0 in any decoded field drives none of that field's lines. No decoded field ever drives more than one line.
- R12: The word 111 100 111 001 000 000 yields `bus_sel` 111, program counter increment, instruction reg load and memory read, and no other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_load | input | 1 | Capture enable for the control data register |
| cw_in | input | 18 | Control part of the microword read from the control store |
| bus_sel | output | 3 | Bus source select, passed through |
| addr_pc_ctl | output | 7 | Address reg / program counter / extension reset lines |
| acc_dr_ctl | output | 7 | Accumulator / data reg / instruction reg lines |
| mem_tr_ctl | output | 7 | Memory strobes, temp reg and interrupt-pending lines |
| alu_op | output | 6 | ALU operation selects |
| out_load | output | 1 | Output register load |
| flag_ctl | output | 5 | Interrupt-enable, run-state and ready-flag resets |

## Verification
Several properties are checked on every cycle: no decoded field drives more than one line, the register captures the word on load and holds it otherwise, reset leaves everything idle, and an output-register load always comes with the output-ready reset. Whether each code reaches the right line in the right bit position, whether codes 6 and 7 of the last field stay silent, and the given example word can only be shown by the bench. It compares every field against decode tables of its own, under random words and under directed corner cases.

// File: rtl/ucw_pkg.sv
package ucw_pkg;

    localparam int FIELD_W    = 3;
    localparam int NUM_FIELDS = 6;
    localparam int CW_W       = FIELD_W * NUM_FIELDS;
    localparam int MAX_LINES  = (1 << FIELD_W) - 1;

    typedef logic [FIELD_W-1:0] field_t;
    // index NUM_FIELDS-1 is group 1 (most significant), index 0 is group 6
    typedef field_t [NUM_FIELDS-1:0] cword_t;

    // group numbers are 1-based, group 1 at the top of the word
    function automatic field_t field_of(input cword_t w, input int grp);
        return w[NUM_FIELDS - grp];
    endfunction

    // number of active codes a decoded group provides
    function automatic int lines_of(input int grp);
        return (grp == NUM_FIELDS) ? 5 : MAX_LINES;
    endfunction

endpackage

// File: rtl/ucw_creg.sv
module ucw_creg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2
    cap_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/ucw_field_dec.sv
module ucw_field_dec #(
    parameter int W      = 3,
    parameter int NLINES = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      code,
    output logic [NLINES-1:0] lines
);
    for (genvar k = 0; k < NLINES; k++) begin : g_line
        assign lines[k] = (code == W'(k + 1));
    end

    // R11
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lines));

    // R11
    nop_chk: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |-> (lines == '0));
endmodule

// File: rtl/ucw_decode.sv
module ucw_decode
    import ucw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cw_load,
    input  logic [CW_W-1:0] cw_in,
    output logic [2:0]      bus_sel,
    output logic [6:0]      addr_pc_ctl,
    output logic [6:0]      acc_dr_ctl,
    output logic [6:0]      mem_tr_ctl,
    output logic [5:0]      alu_op,
    output logic            out_load,
    output logic [4:0]      flag_ctl
);
    logic [CW_W-1:0]      cdr_q;
    cword_t               cw;
    logic [MAX_LINES-1:0] dec [2:NUM_FIELDS];

    ucw_creg #(.W(CW_W)) creg_i (
        .clk  (clk),
        .rst  (rst),
        .load (cw_load),
        .d    (cw_in),
        .q    (cdr_q)
    );

    assign cw = cword_t'(cdr_q);

    for (genvar g = 2; g <= NUM_FIELDS; g++) begin : g_grp
        localparam int NL = lines_of(g);
        logic [NL-1:0] raw;

        ucw_field_dec #(.W(FIELD_W), .NLINES(NL)) dec_i (
            .clk   (clk),
            .rst   (rst),
            .code  (field_of(cw, g)),
            .lines (raw)
        );

        assign dec[g] = MAX_LINES'(raw);
    end

    assign bus_sel     = field_of(cw, 1);
    assign addr_pc_ctl = dec[2];
    assign acc_dr_ctl  = dec[3];
    assign mem_tr_ctl  = dec[4];
    assign alu_op      = dec[5][5:0];
    assign out_load    = dec[5][6];
    // output-register load shares its code with the output-ready reset
    assign flag_ctl    = {dec[6][4] | dec[5][6], dec[6][3:0]};

    // R10
    out_merge_chk: assert property (@(posedge clk) disable iff (rst)
        out_load |-> flag_ctl[4]);

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (bus_sel == '0 && addr_pc_ctl == '0 && acc_dr_ctl == '0 &&
                 mem_tr_ctl == '0 && alu_op == '0 && !out_load && flag_ctl == '0));

    // R4
    bus_pass_chk: assert property (@(posedge clk) disable iff (rst)
        cw_load |=> (bus_sel == $past(cw_in[CW_W-1 -: FIELD_W])));
endmodule

// File: tb/ucw_decode_tb_top.sv
module ucw_decode_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cw_load = 1'b0;
    logic [17:0] cw_in = '0;
    logic [2:0]  bus_sel;
    logic [6:0]  addr_pc_ctl, acc_dr_ctl, mem_tr_ctl;
    logic [5:0]  alu_op;
    logic        out_load;
    logic [4:0]  flag_ctl;

    int checks = 0;
    int errors = 0;
    logic [17:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucw_decode dut_i (
        .clk(clk), .rst(rst), .cw_load(cw_load), .cw_in(cw_in),
        .bus_sel(bus_sel), .addr_pc_ctl(addr_pc_ctl), .acc_dr_ctl(acc_dr_ctl),
        .mem_tr_ctl(mem_tr_ctl), .alu_op(alu_op), .out_load(out_load),
        .flag_ctl(flag_ctl)
    );

    function automatic logic [6:0] exp7(input logic [2:0] c);
        return (c == 3'd0) ? 7'd0 : 7'(1) << (c - 3'd1);
    endfunction

    function automatic logic [6:0] exp_alu(input logic [2:0] c);
        // {out_load, alu_op}
        return exp7(c);
    endfunction

    function automatic logic [4:0] exp_flag(input logic [2:0] c6, input logic [2:0] c5);
        logic [4:0] f;
        f = (c6 >= 3'd1 && c6 <= 3'd5) ? 5'(1) << (c6 - 3'd1) : 5'd0;
        if (c5 == 3'd7) f[4] = 1'b1;
        return f;
    endfunction

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_all(input logic [17:0] w);
        chk("R4 bus_sel",     7'(bus_sel),     7'(w[17:15]));
        chk("R5 addr_pc_ctl", addr_pc_ctl,     exp7(w[14:12]));
        chk("R6 acc_dr_ctl",  acc_dr_ctl,      exp7(w[11:9]));
        chk("R7 mem_tr_ctl",  mem_tr_ctl,      exp7(w[8:6]));
        chk("R8 alu/out",     {out_load, alu_op}, exp_alu(w[5:3]));
        chk("R9 R10 flag_ctl", 7'(flag_ctl),   7'(exp_flag(w[2:0], w[5:3])));
    endtask

    // drive at falling edge, let one rising edge pass, sample at next falling edge
    task automatic step(input logic ld, input logic [17:0] w);
        cw_load = ld;
        cw_in   = w;
        @(posedge clk);
        if (rst) model = '0;
        else if (ld) model = w;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(1'b1, 18'h3FFFF);
        // R1: reset state
        chk("R1 reset", {bus_sel, addr_pc_ctl[3:0]}, 7'd0);
        check_all(18'd0);
        rst = 1'b0;

        // R12: example word
        step(1'b1, 18'b111_100_111_001_000_000);
        check_all(18'b111_100_111_001_000_000);
        chk("R12 pc_inc",  7'(addr_pc_ctl[3]), 7'd1);
        chk("R12 ir_load", 7'(acc_dr_ctl[6]),  7'd1);
        chk("R12 mem_rd",  7'(mem_tr_ctl[0]),  7'd1);

        // R3: hold while load low
        step(1'b0, 18'b000_001_010_011_100_101);
        check_all(18'b111_100_111_001_000_000);

        // R11: all-zero fields give nothing
        step(1'b1, 18'd0);
        check_all(18'd0);

        // R10: output load alone asserts output-ready reset
        step(1'b1, 18'b000_000_000_000_111_000);
        chk("R10 out_load", 7'(out_load), 7'd1);
        chk("R10 out_flag", 7'(flag_ctl[4]), 7'd1);

        // R9: codes 6 and 7 of last field are no-operation
        step(1'b1, 18'b000_000_000_000_000_110);
        chk("R9 code6", 7'(flag_ctl), 7'd0);
        step(1'b1, 18'b000_000_000_000_000_111);
        chk("R9 code7", 7'(flag_ctl), 7'd0);

        // R5..R9 sweep every code in every field
        for (int c = 0; c < 8; c++) begin
            logic [17:0] w;
            w = {6{3'(c)}};
            step(1'b1, w);
            check_all(w);
        end

        // R2/R3 random mix
        for (int i = 0; i < 400; i++) begin
            logic        ld;
            logic [17:0] w;
            ld = 1'($urandom);
            w  = 18'($urandom);
            step(ld, w);
            check_all(model);
        end

        // R1: reset mid-run
        step(1'b1, 18'h2AAAA);
        rst = 1'b1;
        step(1'b1, 18'h15555);
        check_all(18'd0);
        rst = 1'b0;
        step(1'b0, 18'h15555);
        chk("R1 after reset hold", 7'(bus_sel), 7'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule